// File: doc/BRIEF.md
# Power-Fail SRAM Chip-Enable Guard

This block protects two battery-backed static RAM banks from stray writes while the main supply is failing and while it recovers. A host presents one active-low chip enable and a bank-select bit. While the supply is healthy, the enable is steered with no added clock latency to one of two conditioned active-low bank enables. When the supply drops below the power-fail threshold, both bank enables are forced inactive. They stay inactive until the supply has been valid without a break for a programmable number of clock cycles.

External analog comparators supply three flags: supply above the power-fail threshold, supply above the backup cell voltage, and backup cell above the power-fail threshold. Each flag passes through a two-flop synchronizer. From the synchronized flags the block chooses the power source for the external supply switch. It also drives an active-low processor reset, which is released at the moment memory access becomes allowed. A status output shows when write protection is active.

Top module: `sram_guard`

## Requirements
- R1: While `host_cs_n` is high, every bit of `cs_n` is high.
- R2: While unprotected, with `host_cs_n` low and `bank_sel` equal to 0, `cs_n[0]` is low and `cs_n[1]` is high. This follows the live inputs in the same cycle.
- R3: While unprotected, with `host_cs_n` low and `bank_sel` equal to 1, `cs_n[1]` is low and `cs_n[0]` is high. This follows the live inputs in the same cycle.
- R4: Two rising clock edges after `vdd_ok_a` goes low, `protect` is high and all of `cs_n` is high, whatever `host_cs_n` and `bank_sel` do.
- R5: After `vdd_ok_a` rises, `protect` stays high through rising edge HOLD+1 counted from the rise, and falls at edge HOLD+2. This is two synchronizer edges plus HOLD edges with the supply valid.
- R6: A low pulse on `vdd_ok_a` that is one cycle long during the recovery window restarts the count. Release then happens HOLD+2 edges after the final rise.
- R7: With the synchronized supply below threshold, `use_backup` is 1 in two cases: the backup cell is above threshold, or the backup cell is below threshold and the supply is below the cell. Otherwise it is 0.
- R8: Whenever the synchronized supply flag is high, `use_backup` is 0.
- R9: `cpu_rst_n` is always the inverse of `protect`.
- R10: During and right after reset, `protect` is high, `cpu_rst_n` is low and every bit of `cs_n` is high. All synchronizer stages reset to 0.
- R11: A change on any comparator flag reaches `use_backup` after exactly two rising edges, not one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip enable, active low |
| bank_sel | input | SEL_W | Bank select |
| vdd_ok_a | input | 1 | Async flag: supply above power-fail threshold |
| vdd_gt_bat_a | input | 1 | Async flag: supply above backup cell voltage |
| bat_ok_a | input | 1 | Async flag: backup cell above power-fail threshold |
| cs_n | output | 2**SEL_W | Conditioned bank enables, active low |
| cpu_rst_n | output | 1 | Processor reset, active low |
| use_backup | output | 1 | Supply switch select: 1 = backup cell |
| protect | output | 1 | High while write protection is active |

## Verification
The hardest case to reach is a supply dip inside the recovery window. A short low pulse must be wide enough to survive the synchronizer, and its timing must be known relative to the counting edges. The bench produces it by directed stimulus. After the supply rises, it waits part of the window, drives the supply flag low for exactly one clock, then counts edges from the final rise and checks the release edge and the edge before it. Random phases add rare supply flips between long valid stretches. An edge-accurate model in the bench follows the synchronizer and the hold count during these phases.

// File: rtl/sg_pkg.sv
package sg_pkg;
    typedef enum logic {
        PH_GUARD = 1'b0,
        PH_OPEN  = 1'b1
    } phase_e;

    typedef enum logic {
        SRC_MAIN   = 1'b0,
        SRC_BACKUP = 1'b1
    } src_e;

    typedef struct packed {
        logic vdd_ok;
        logic vdd_gt_bat;
        logic bat_ok;
    } cmp_flags_t;

    localparam int FLAG_W = $bits(cmp_flags_t);
endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/sg_hold_timer.sv
module sg_hold_timer
    import sg_pkg::*;
#(
    parameter int HOLD = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    output logic blocked
);
    localparam int CNT_W = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!supply_ok) begin
            st_d.phase = PH_GUARD;
            st_d.cnt   = '0;
        end else if (st_q.phase == PH_GUARD) begin
            if (st_q.cnt == LAST) begin
                st_d.phase = PH_OPEN;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_GUARD;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign blocked = (st_q.phase == PH_GUARD) || !supply_ok;
endmodule

// File: rtl/sg_src_sel.sv
module sg_src_sel
    import sg_pkg::*;
(
    input  cmp_flags_t flags,
    output src_e       src
);
    always_comb begin
        src = SRC_MAIN;
        if (!flags.vdd_ok) begin
            if (flags.bat_ok)
                src = SRC_BACKUP;
            else if (!flags.vdd_gt_bat)
                src = SRC_BACKUP;
        end
    end
endmodule

// File: rtl/sg_cs_gate.sv
module sg_cs_gate #(
    parameter int SEL_W = 1
) (
    input  logic                    blocked,
    input  logic                    host_cs_n,
    input  logic [SEL_W-1:0]        bank_sel,
    output logic [(1<<SEL_W)-1:0]   cs_n
);
    localparam int BANKS = 1 << SEL_W;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign cs_n[b] = blocked || host_cs_n || (bank_sel != SEL_W'(b));
    end
endmodule

// File: rtl/sram_guard.sv
module sram_guard
    import sg_pkg::*;
#(
    parameter int SEL_W = 1,
    parameter int HOLD  = 1024
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_cs_n,
    input  logic [SEL_W-1:0]      bank_sel,
    input  logic                  vdd_ok_a,
    input  logic                  vdd_gt_bat_a,
    input  logic                  bat_ok_a,
    output logic [(1<<SEL_W)-1:0] cs_n,
    output logic                  cpu_rst_n,
    output logic                  use_backup,
    output logic                  protect
);
    cmp_flags_t flags_a, flags_s;
    src_e       src;
    logic       vdd_ok_s;
    logic       blocked;

    assign flags_a.vdd_ok     = vdd_ok_a;
    assign flags_a.vdd_gt_bat = vdd_gt_bat_a;
    assign flags_a.bat_ok     = bat_ok_a;

    sg_sync #(.WIDTH(FLAG_W), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (flags_a),
        .dout (flags_s)
    );

    assign vdd_ok_s = flags_s.vdd_ok;

    sg_hold_timer #(.HOLD(HOLD)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .supply_ok(vdd_ok_s),
        .blocked  (blocked)
    );

    sg_src_sel u_src (
        .flags(flags_s),
        .src  (src)
    );

    sg_cs_gate #(.SEL_W(SEL_W)) u_gate (
        .blocked  (blocked),
        .host_cs_n(host_cs_n),
        .bank_sel (bank_sel),
        .cs_n     (cs_n)
    );

    assign use_backup = (src == SRC_BACKUP);
    assign cpu_rst_n  = !blocked;
    assign protect    = blocked;
endmodule

// File: rtl/sram_guard_chk.sv
module sram_guard_chk #(
    parameter int SEL_W = 1,
    parameter int HOLD  = 1024
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  host_cs_n,
    input logic [SEL_W-1:0]      bank_sel,
    input logic                  vdd_ok_s,
    input logic [(1<<SEL_W)-1:0] cs_n,
    input logic                  cpu_rst_n,
    input logic                  use_backup,
    input logic                  protect
);
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   run_q <= '0;
        else if (!vdd_ok_s)           run_q <= '0;
        else if (run_q < 32'(HOLD))   run_q <= run_q + 32'd1;
    end

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        host_cs_n |-> (&cs_n));

    assert_one_bank_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!protect && !host_cs_n) |-> ($countones(~cs_n) == 1 && !cs_n[bank_sel]));

    assert_fail_forces_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !vdd_ok_s |-> (protect && (&cs_n)));

    assert_release_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(protect) |-> (run_q >= 32'(HOLD)));

    assert_release_due_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vdd_ok_s && run_q >= 32'(HOLD)) |-> !protect);

    assert_main_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_ok_s |-> !use_backup);

    assert_rst_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst_n == !protect);
endmodule

bind sram_guard sram_guard_chk #(.SEL_W(SEL_W), .HOLD(HOLD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_cs_n (host_cs_n),
    .bank_sel  (bank_sel),
    .vdd_ok_s  (vdd_ok_s),
    .cs_n      (cs_n),
    .cpu_rst_n (cpu_rst_n),
    .use_backup(use_backup),
    .protect   (protect)
);

// File: tb/sram_guard_bench.sv
`timescale 1ns/1ps
module sram_guard_bench;
    localparam int HOLD = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_cs_n = 1'b1;
    logic [0:0] bank_sel = 1'b0;
    logic       vdd_ok_a = 1'b1;
    logic       vdd_gt_bat_a = 1'b1;
    logic       bat_ok_a = 1'b1;
    logic [1:0] cs_n;
    logic       cpu_rst_n, use_backup, protect;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    sram_guard #(.SEL_W(1), .HOLD(HOLD)) u_sram_guard (
        .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .bank_sel(bank_sel),
        .vdd_ok_a(vdd_ok_a), .vdd_gt_bat_a(vdd_gt_bat_a), .bat_ok_a(bat_ok_a),
        .cs_n(cs_n), .cpu_rst_n(cpu_rst_n), .use_backup(use_backup), .protect(protect)
    );

    // edge-accurate model built from the requirements: flags {vdd, gt, bat}
    logic [2:0] m_s1, m_s2;
    int         m_run;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_run <= 0;
        end else begin
            if (!m_s2[2])          m_run <= 0;
            else if (m_run < HOLD) m_run <= m_run + 1;
            m_s2 <= m_s1;
            m_s1 <= {vdd_ok_a, vdd_gt_bat_a, bat_ok_a};
        end
    end

    function automatic logic exp_blocked();
        return !m_s2[2] || (m_run < HOLD);
    endfunction

    function automatic logic [1:0] exp_cs(logic blk, logic cs, logic sel);
        if (blk || cs) return 2'b11;
        return sel ? 2'b01 : 2'b10;
    endfunction

    function automatic logic exp_backup(logic [2:0] f);
        if (f[2]) return 1'b0;
        return f[0] || !f[1];
    endfunction

    task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: %s got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_cs();
        logic b;
        string req;
        b = exp_blocked();
        if (b) req = "R4";
        else if (host_cs_n) req = "R1";
        else if (bank_sel[0]) req = "R3";
        else req = "R2";
        cmp(req, "cs_n", 32'(cs_n), 32'(exp_cs(b, host_cs_n, bank_sel[0])));
    endtask

    task automatic check_all();
        check_cs();
        cmp("R4", "protect", 32'(protect), 32'(exp_blocked()));
        cmp("R9", "cpu_rst_n", 32'(cpu_rst_n), 32'(!exp_blocked()));
        cmp(m_s2[2] ? "R8" : "R7", "use_backup", 32'(use_backup), 32'(exp_backup(m_s2)));
    endtask

    task automatic tick();
        @(negedge clk);
        #2;
        check_all();
    endtask

    task automatic drive_cs(logic cs, logic sel);
        host_cs_n = cs;
        bank_sel  = sel;
        #1;
        check_cs();
    endtask

    task automatic wait_open_from_rise();
        for (int k = 1; k <= HOLD + 2; k++) begin
            tick();
            if (k == HOLD + 1) cmp("R5", "protect before release", 32'(protect), 32'd1);
            if (k == HOLD + 2) cmp("R5", "protect at release", 32'(protect), 32'd0);
        end
    endtask

    initial begin
        void'($urandom(32'd7031));
        #3;
        cmp("R10", "protect in reset", 32'(protect), 32'd1);
        cmp("R10", "cpu_rst_n in reset", 32'(cpu_rst_n), 32'd0);
        host_cs_n = 1'b0;
        #1;
        cmp("R10", "cs_n in reset", 32'(cs_n), 32'h3);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;          // vdd_ok_a already high: count from release
        #2;
        cmp("R10", "protect after reset", 32'(protect), 32'd1);
        wait_open_from_rise();

        // pass-through, same cycle
        drive_cs(1'b0, 1'b0);
        cmp("R2", "bank 0 enable", 32'(cs_n), 32'h2);
        drive_cs(1'b0, 1'b1);
        cmp("R3", "bank 1 enable", 32'(cs_n), 32'h1);
        drive_cs(1'b1, 1'b1);
        cmp("R1", "idle", 32'(cs_n), 32'h3);

        // supply failure: forced after two edges
        host_cs_n = 1'b0;
        tick();
        vdd_ok_a = 1'b0;
        tick();
        cmp("R4", "protect after one edge", 32'(protect), 32'd0);
        tick();
        cmp("R4", "protect after two edges", 32'(protect), 32'd1);
        drive_cs(1'b0, 1'b0);
        cmp("R4", "cs_n forced", 32'(cs_n), 32'h3);

        // source selection latency and rule while supply is low
        bat_ok_a = 1'b1; vdd_gt_bat_a = 1'b1;
        tick(); tick();
        cmp("R7", "backup with cell ok", 32'(use_backup), 32'd1);
        bat_ok_a = 1'b0;
        tick();
        cmp("R11", "one edge unchanged", 32'(use_backup), 32'd1);
        tick();
        cmp("R7", "main when supply above weak cell", 32'(use_backup), 32'd0);
        vdd_gt_bat_a = 1'b0;
        tick(); tick();
        cmp("R11", "backup when supply below weak cell", 32'(use_backup), 32'd1);

        // recovery with a dip in the middle of the window
        vdd_ok_a = 1'b1;
        repeat (HOLD / 2) tick();
        cmp("R6", "still protected mid window", 32'(protect), 32'd1);
        vdd_ok_a = 1'b0;
        tick();
        vdd_ok_a = 1'b1;
        tick();
        tick();
        cmp("R6", "dip seen by timer", 32'(protect), 32'd1);
        for (int k = 3; k <= HOLD + 2; k++) begin
            tick();
            if (k == HOLD + 1) cmp("R6", "restarted count not yet done", 32'(protect), 32'd1);
            if (k == HOLD + 2) cmp("R6", "release after restart", 32'(protect), 32'd0);
        end
        cmp("R8", "main after recovery", 32'(use_backup), 32'd0);

        // constrained random phase
        for (int n = 0; n < 4000; n++) begin
            tick();
            if ($urandom % 60 == 0) vdd_ok_a = ~vdd_ok_a;
            if ($urandom % 8 == 0)  bat_ok_a = $urandom % 2;
            if ($urandom % 8 == 0)  vdd_gt_bat_a = $urandom % 2;
            drive_cs(1'($urandom % 2), 1'($urandom % 2));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule